// File: doc/BRIEF.md
# Paged Descriptor Ring Address Generator

This block produces the physical descriptor addresses for three circular rings that a storage host adapter shares with its driver. The request ring is consumed by the device. The completion ring and the message ring are produced by the device. Each ring is backed by a small table of page base addresses. A descriptor's address is found from a free-running 32-bit private pointer: the pointer is masked to a ring index, the index is split into a page select and an in-page slot, and the slot is scaled by the descriptor size of that ring.

A setup sequence loads one ring at a time. It takes a page count and then one page frame number per cycle. After the last page it spends one commit cycle. In that cycle it derives the ring's length exponent and index mask, clears the ring's private pointer, and resets the ring's shared indices. The shared producer, consumer and exponent words live in a small register file. The host side writes and reads that file through a simple register port. The block's own writes take precedence.

Pop, flush and cleanup are single-cycle operations. Each one is acknowledged on the following cycle. The three rings differ in how they are checked. A request pop fails when the ring is empty. A completion pop never fails. The message ring offers a continuous room flag.

Top module: `ring_addr_gen`

## Requirements
- R1: A setup starts when `cfg_start` is high in idle, with `cfg_ring` in 0..2 and `cfg_npages` in 1..MAX_PAGES; otherwise it is ignored. `cfg_busy` rises the cycle after the start. The block then takes one page frame per cycle of `cfg_ppn_valid` and stores it as page base `cfg_ppn << PAGE_SHIFT`. After the last page it spends one commit cycle, and `cfg_busy` falls after that cycle.
- R2: On commit, the ring size is the page count times that ring's entries per page. The exponent is the smallest e ≥ 1 for which (size − 1) >> e is zero. This exponent is stored in the ring's exponent word, and the index mask becomes 2^e − 1.
- R3: On commit, the ring's private pointer is cleared and its shared producer and consumer words are set to zero.
- R4: A request-ring pop with the shared request producer equal to the consumed pointer is acknowledged with `addr_valid` low and `addr` zero, and it leaves the pointer unchanged.
- R5: A successful pop forms idx = pointer & mask. The page is idx / EPP and the slot is idx % EPP. The result is `addr` = base[page] + slot × DSZ, where a page beyond the table reads as base 0. The pointer then increments by one.
- R6: A completion-ring pop always returns `addr_valid` high, even after more pops than the ring size. Its index wraps through the mask.
- R7: `msg_room` is high exactly when (message producer − message consumer), taken modulo 2^32, is less than the message mask plus one.
- R8: Flushing ring 0 writes the consumed pointer into its consumer word. Flushing ring 1 or 2 writes the fill pointer into that ring's producer word. A flush acknowledges with `addr_valid` low.
- R9: A cleanup zeroes all three masks, all three private pointers and every page base. It leaves the shared words untouched.
- R10: Operation codes are 0 pop, 1 flush, 2 cleanup and 3 none. Rings are 0 request, 1 completion and 2 message. An operation is accepted in idle when its ring is 0..2, its code is 0..2, and no setup starts in the same cycle. `op_ack` is high exactly one cycle after acceptance. An ignored operation gets no acknowledge and changes nothing.
- R11: Register address {ring[1:0], field[1:0]} selects field 0 producer, 1 consumer or 2 exponent. `sh_rdata` shows the addressed word combinationally. Any other address reads zero and ignores writes. The block's own writes override a host write to the same word in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start | input | 1 | Begin a ring setup |
| cfg_ring | input | 2 | Ring to set up |
| cfg_npages | input | CNT_W | Page count for the setup |
| cfg_ppn_valid | input | 1 | A page frame number is present |
| cfg_ppn | input | ADDR_W-PAGE_SHIFT | Page frame number |
| cfg_busy | output | 1 | Setup in progress |
| op_valid | input | 1 | Operation request |
| op_code | input | 2 | Operation code |
| op_ring | input | 2 | Ring the operation targets |
| op_ack | output | 1 | Operation acknowledge |
| addr_valid | output | 1 | `addr` holds a descriptor address |
| addr | output | ADDR_W | Descriptor address |
| sh_we | input | 1 | Host write to the shared register file |
| sh_waddr | input | 4 | Host write address |
| sh_wdata | input | 32 | Host write data |
| sh_raddr | input | 4 | Host read address |
| sh_rdata | output | 32 | Host read data |
| msg_room | output | 1 | Message ring has room |

## Verification
Operation results (`op_ack`, `addr_valid`, `addr`) and pointer or shared-word updates appear on the first rising edge after the request. For that reason every operation is driven on a falling edge and checked on the next falling edge, before any new stimulus. `cfg_busy` is checked one edge after the start, again at the commit cycle that follows the last page, and clear one edge later. The commit results are read back through the combinational register port at that point. `msg_room` and register reads follow the stored words with no register stage, so they are sampled a short delay after the address is set, within the same low clock phase.

// File: rtl/ring_pkg.sv
package ring_pkg;

    localparam int NUM_RINGS = 3;
    localparam int NUM_SLOTS = 4;
    localparam int PTR_W     = 32;

    typedef enum logic [1:0] {
        RING_REQ  = 2'd0,
        RING_CMP  = 2'd1,
        RING_MSG  = 2'd2,
        RING_NONE = 2'd3
    } ring_e;

    typedef enum logic [1:0] {
        OP_POP     = 2'd0,
        OP_FLUSH   = 2'd1,
        OP_CLEANUP = 2'd2,
        OP_NONE    = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        FLD_PROD = 2'd0,
        FLD_CONS = 2'd1,
        FLD_EXP  = 2'd2,
        FLD_NONE = 2'd3
    } fld_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOAD   = 2'd1,
        ST_COMMIT = 2'd2
    } cfg_state_e;

    // Smallest e >= 1 with (size_m1 >> e) == 0.
    function automatic logic [5:0] len_exp(input logic [PTR_W-1:0] size_m1);
        logic [5:0] e;
        e = 6'd1;
        for (int b = 1; b < PTR_W; b++) begin
            if ((size_m1 >> b) != '0) e = 6'(b + 1);
        end
        return e;
    endfunction

    function automatic logic [PTR_W-1:0] exp_mask(input logic [5:0] e);
        if (e >= 6'd32) return '1;
        return (PTR_W'(1) << e) - PTR_W'(1);
    endfunction

endpackage

// File: rtl/ring_page_table.sv
module ring_page_table #(
    parameter int ADDR_W    = 48,
    parameter int MAX_PAGES = 8,
    parameter int PG_W      = 3,
    parameter int EPP       = 32,
    parameter int DSZ       = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PG_W-1:0]   wr_page,
    input  logic [ADDR_W-1:0] wr_base,
    input  logic              clr,
    input  logic [31:0]       idx,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] base_q [MAX_PAGES];
    logic [31:0]       page_sel;
    logic [31:0]       slot;
    logic [31:0]       slot_off;
    logic [ADDR_W-1:0] base_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < MAX_PAGES; p++) base_q[p] <= '0;
        end else if (clr) begin
            for (int p = 0; p < MAX_PAGES; p++) base_q[p] <= '0;
        end else if (wr_en) begin
            for (int p = 0; p < MAX_PAGES; p++) begin
                if (wr_page == PG_W'(p)) base_q[p] <= wr_base;
            end
        end
    end

    assign page_sel = idx / 32'(EPP);
    assign slot     = idx % 32'(EPP);
    assign slot_off = slot * 32'(DSZ);

    always_comb begin
        base_sel = '0;
        for (int p = 0; p < MAX_PAGES; p++) begin
            if (page_sel == 32'(p)) base_sel = base_q[p];
        end
    end

    assign addr = base_sel + ADDR_W'(slot_off);

endmodule

// File: rtl/ring_shared_regs.sv
module ring_shared_regs
    import ring_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_we,
    input  logic [3:0]  host_waddr,
    input  logic [31:0] host_wdata,
    input  logic [3:0]  host_raddr,
    output logic [31:0] host_rdata,
    input  logic        commit_en,
    input  logic [1:0]  commit_ring,
    input  logic [31:0] commit_exp,
    input  logic        flush_en,
    input  logic [1:0]  flush_ring,
    input  logic [31:0] flush_val,
    output logic [31:0] req_prod,
    output logic [31:0] msg_prod,
    output logic [31:0] msg_cons
);

    logic [16*32-1:0] flat;

    for (genvar r = 0; r < NUM_SLOTS; r++) begin : g_ring
        for (genvar f = 0; f < 4; f++) begin : g_fld
            if (r < NUM_RINGS && f < 3) begin : g_word
                localparam int FLUSH_FLD = (r == 0) ? int'(FLD_CONS) : int'(FLD_PROD);
                logic [31:0] word_q;
                logic        hit_host;
                logic        hit_commit;
                logic        hit_flush;

                assign hit_host   = host_we && (host_waddr == 4'(r * 4 + f));
                assign hit_commit = commit_en && (commit_ring == 2'(r));
                assign hit_flush  = flush_en && (flush_ring == 2'(r)) && (f == FLUSH_FLD);

                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        word_q <= '0;
                    end else if (hit_commit) begin
                        word_q <= (f == int'(FLD_EXP)) ? commit_exp : 32'd0;
                    end else if (hit_flush) begin
                        word_q <= flush_val;
                    end else if (hit_host) begin
                        word_q <= host_wdata;
                    end
                end
                assign flat[(r * 4 + f) * 32 +: 32] = word_q;
            end else begin : g_hole
                assign flat[(r * 4 + f) * 32 +: 32] = 32'd0;
            end
        end
    end

    assign host_rdata = flat[host_raddr * 32 +: 32];
    assign req_prod   = flat[(0 * 4 + 0) * 32 +: 32];
    assign msg_prod   = flat[(2 * 4 + 0) * 32 +: 32];
    assign msg_cons   = flat[(2 * 4 + 1) * 32 +: 32];

endmodule

// File: rtl/ring_addr_gen.sv
module ring_addr_gen
    import ring_pkg::*;
#(
    parameter int ADDR_W     = 48,
    parameter int PAGE_SHIFT = 12,
    parameter int MAX_PAGES  = 8,
    parameter int REQ_EPP    = 32,
    parameter int CMP_EPP    = 128,
    parameter int MSG_EPP    = 64,
    parameter int REQ_DSZ    = 128,
    parameter int CMP_DSZ    = 32,
    parameter int MSG_DSZ    = 64,
    localparam int PPN_W     = ADDR_W - PAGE_SHIFT,
    localparam int CNT_W     = $clog2(MAX_PAGES + 1),
    localparam int PG_W      = (MAX_PAGES > 1) ? $clog2(MAX_PAGES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_start,
    input  logic [1:0]        cfg_ring,
    input  logic [CNT_W-1:0]  cfg_npages,
    input  logic              cfg_ppn_valid,
    input  logic [PPN_W-1:0]  cfg_ppn,
    output logic              cfg_busy,
    input  logic              op_valid,
    input  logic [1:0]        op_code,
    input  logic [1:0]        op_ring,
    output logic              op_ack,
    output logic              addr_valid,
    output logic [ADDR_W-1:0] addr,
    input  logic              sh_we,
    input  logic [3:0]        sh_waddr,
    input  logic [31:0]       sh_wdata,
    input  logic [3:0]        sh_raddr,
    output logic [31:0]       sh_rdata,
    output logic              msg_room
);

    cfg_state_e state_q, state_d;

    logic [1:0]       cfg_ring_q;
    logic [CNT_W-1:0] npages_q;
    logic [CNT_W-1:0] ld_cnt_q;
    logic             cfg_go;
    logic             ld_last;
    logic             load_we;
    logic             commit_now;
    logic [31:0]      ring_epp;
    logic [31:0]      ring_size;
    logic [5:0]       commit_e;
    logic [31:0]      commit_mask;
    logic [ADDR_W-1:0] wr_base;

    logic             op_go;
    logic             clean_go;
    logic             flush_go;
    logic             pop_ok;
    logic [31:0]      sel_ptr;
    logic [ADDR_W-1:0] sel_addr;

    logic [NUM_SLOTS*32-1:0]     ptr_all;
    logic [NUM_SLOTS*32-1:0]     mask_all;
    logic [NUM_SLOTS*ADDR_W-1:0] addr_all;

    logic [31:0] req_prod;
    logic [31:0] msg_prod;
    logic [31:0] msg_cons;

    logic              op_ack_q;
    logic              addr_valid_q;
    logic [ADDR_W-1:0] addr_q;

    // ---------------- setup state machine ----------------
    assign cfg_go = (state_q == ST_IDLE) && cfg_start && (cfg_ring != RING_NONE) &&
                    (cfg_npages != '0) && (int'(cfg_npages) <= MAX_PAGES);
    assign ld_last    = (ld_cnt_q == CNT_W'(npages_q - CNT_W'(1)));
    assign load_we    = (state_q == ST_LOAD) && cfg_ppn_valid;
    assign commit_now = (state_q == ST_COMMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cfg_go) state_d = ST_LOAD;
            ST_LOAD:   if (cfg_ppn_valid && ld_last) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        cfg_busy = (state_q != ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_ring_q <= '0;
            npages_q   <= '0;
            ld_cnt_q   <= '0;
        end else if (cfg_go) begin
            cfg_ring_q <= cfg_ring;
            npages_q   <= cfg_npages;
            ld_cnt_q   <= '0;
        end else if (load_we) begin
            ld_cnt_q   <= ld_cnt_q + CNT_W'(1);
        end
    end

    always_comb begin
        unique case (cfg_ring_q)
            RING_REQ: ring_epp = 32'(REQ_EPP);
            RING_CMP: ring_epp = 32'(CMP_EPP);
            RING_MSG: ring_epp = 32'(MSG_EPP);
            default:  ring_epp = 32'd1;
        endcase
    end

    assign ring_size   = 32'(npages_q) * ring_epp;
    assign commit_e    = len_exp(ring_size - 32'd1);
    assign commit_mask = exp_mask(commit_e);
    assign wr_base     = {cfg_ppn, {PAGE_SHIFT{1'b0}}};

    // ---------------- operation decode ----------------
    assign op_go    = (state_q == ST_IDLE) && !cfg_go && op_valid &&
                      (op_ring != RING_NONE) && (op_code != OP_NONE);
    assign clean_go = op_go && (op_code == OP_CLEANUP);
    assign flush_go = op_go && (op_code == OP_FLUSH);
    assign sel_ptr  = ptr_all[op_ring * 32 +: 32];
    assign sel_addr = addr_all[op_ring * ADDR_W +: ADDR_W];
    assign pop_ok   = (op_ring != RING_REQ) || (req_prod != sel_ptr);

    // ---------------- per-ring pointer, mask and page table ----------------
    for (genvar r = 0; r < NUM_RINGS; r++) begin : g_ring
        localparam int EPP = (r == 0) ? REQ_EPP : (r == 1) ? CMP_EPP : MSG_EPP;
        localparam int DSZ = (r == 0) ? REQ_DSZ : (r == 1) ? CMP_DSZ : MSG_DSZ;
        logic [31:0]       ptr_q;
        logic [31:0]       mask_q;
        logic [ADDR_W-1:0] ring_addr;
        logic              mine;

        assign mine = (op_ring == 2'(r));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ptr_q  <= '0;
                mask_q <= '0;
            end else if (commit_now && cfg_ring_q == 2'(r)) begin
                ptr_q  <= '0;
                mask_q <= commit_mask;
            end else if (clean_go) begin
                ptr_q  <= '0;
                mask_q <= '0;
            end else if (op_go && mine && op_code == OP_POP && pop_ok) begin
                ptr_q  <= ptr_q + 32'd1;
            end
        end

        ring_page_table #(
            .ADDR_W   (ADDR_W),
            .MAX_PAGES(MAX_PAGES),
            .PG_W     (PG_W),
            .EPP      (EPP),
            .DSZ      (DSZ)
        ) u_table (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (load_we && cfg_ring_q == 2'(r)),
            .wr_page(ld_cnt_q[PG_W-1:0]),
            .wr_base(wr_base),
            .clr    (clean_go),
            .idx    (ptr_q & mask_q),
            .addr   (ring_addr)
        );

        assign ptr_all[r * 32 +: 32]          = ptr_q;
        assign mask_all[r * 32 +: 32]         = mask_q;
        assign addr_all[r * ADDR_W +: ADDR_W] = ring_addr;
    end

    assign ptr_all[3 * 32 +: 32]          = '0;
    assign mask_all[3 * 32 +: 32]         = '0;
    assign addr_all[3 * ADDR_W +: ADDR_W] = '0;

    // ---------------- shared index storage ----------------
    ring_shared_regs u_shared (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (sh_we),
        .host_waddr (sh_waddr),
        .host_wdata (sh_wdata),
        .host_raddr (sh_raddr),
        .host_rdata (sh_rdata),
        .commit_en  (commit_now),
        .commit_ring(cfg_ring_q),
        .commit_exp (32'(commit_e)),
        .flush_en   (flush_go),
        .flush_ring (op_ring),
        .flush_val  (sel_ptr),
        .req_prod   (req_prod),
        .msg_prod   (msg_prod),
        .msg_cons   (msg_cons)
    );

    assign msg_room = (msg_prod - msg_cons) < (mask_all[2 * 32 +: 32] + 32'd1);

    // ---------------- response register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_ack_q     <= 1'b0;
            addr_valid_q <= 1'b0;
            addr_q       <= '0;
        end else begin
            op_ack_q     <= op_go;
            addr_valid_q <= op_go && (op_code == OP_POP) && pop_ok;
            addr_q       <= (op_go && (op_code == OP_POP) && pop_ok) ? sel_addr : '0;
        end
    end

    assign op_ack     = op_ack_q;
    assign addr_valid = addr_valid_q;
    assign addr       = addr_q;

endmodule

// File: rtl/ring_addr_gen_chk.sv
module ring_addr_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_start,
    input logic       cfg_busy,
    input logic       op_valid,
    input logic [1:0] op_code,
    input logic [1:0] op_ring,
    input logic       op_ack,
    input logic       addr_valid
);

    assert_busy_after_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_busy) |-> $past(cfg_start));

    assert_ack_only_after_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
        op_ack |-> $past(op_valid && !cfg_busy));

    assert_ack_follows_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !cfg_busy && !cfg_start && op_ring != 2'd3 && op_code != 2'd3) |=> op_ack);

    assert_addr_with_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> op_ack);

    assert_cmp_pop_never_fails_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !cfg_busy && !cfg_start && op_code == 2'd0 && op_ring == 2'd1) |=> addr_valid);

    assert_flush_no_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !cfg_busy && !cfg_start && op_code == 2'd1 && op_ring != 2'd3)
            |=> (op_ack && !addr_valid));

endmodule

bind ring_addr_gen ring_addr_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_start (cfg_start),
    .cfg_busy  (cfg_busy),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .op_ring   (op_ring),
    .op_ack    (op_ack),
    .addr_valid(addr_valid)
);

// File: tb/tb_ring_addr_gen.sv
module tb_ring_addr_gen;

    localparam int CLK_PERIOD = 10;
    localparam int AW  = 40;
    localparam int PS  = 12;
    localparam int MP  = 4;
    localparam int CW  = $clog2(MP + 1);
    localparam int PW  = AW - PS;

    // vector: {kind[1:0], ring[1:0], data[7:0]}; kind 0 pop, 1 flush, 2 host prod write, 3 host cons write
    localparam int NV = 19;
    localparam logic [11:0] VEC [NV] = '{
        {2'd0, 2'd0, 8'd0},  {2'd2, 2'd0, 8'd3},  {2'd0, 2'd0, 8'd0},  {2'd0, 2'd0, 8'd0},
        {2'd0, 2'd1, 8'd0},  {2'd0, 2'd0, 8'd0},  {2'd0, 2'd0, 8'd0},  {2'd1, 2'd0, 8'd0},
        {2'd0, 2'd2, 8'd0},  {2'd0, 2'd2, 8'd0},  {2'd1, 2'd2, 8'd0},  {2'd0, 2'd1, 8'd0},
        {2'd1, 2'd1, 8'd0},  {2'd3, 2'd2, 8'd1},  {2'd0, 2'd2, 8'd0},  {2'd1, 2'd2, 8'd0},
        {2'd2, 2'd0, 8'd9},  {2'd0, 2'd0, 8'd0},  {2'd0, 2'd0, 8'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_start = 1'b0;
    logic [1:0] cfg_ring = '0;
    logic [CW-1:0] cfg_npages = '0;
    logic cfg_ppn_valid = 1'b0;
    logic [PW-1:0] cfg_ppn = '0;
    logic cfg_busy;
    logic op_valid = 1'b0;
    logic [1:0] op_code = '0;
    logic [1:0] op_ring = '0;
    logic op_ack, addr_valid;
    logic [AW-1:0] addr;
    logic sh_we = 1'b0;
    logic [3:0] sh_waddr = '0;
    logic [31:0] sh_wdata = '0;
    logic [3:0] sh_raddr = '0;
    logic [31:0] sh_rdata;
    logic msg_room;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // bench model
    logic [AW-1:0] mbase [3][MP];
    logic [31:0] mptr [3];
    logic [31:0] mmask [3];
    logic [31:0] msh [3][3];

    always #(CLK_PERIOD / 2) clk = ~clk;

    ring_addr_gen #(
        .ADDR_W(AW), .PAGE_SHIFT(PS), .MAX_PAGES(MP),
        .REQ_EPP(4), .CMP_EPP(8), .MSG_EPP(2),
        .REQ_DSZ(128), .CMP_DSZ(32), .MSG_DSZ(64)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_start(cfg_start), .cfg_ring(cfg_ring), .cfg_npages(cfg_npages),
        .cfg_ppn_valid(cfg_ppn_valid), .cfg_ppn(cfg_ppn), .cfg_busy(cfg_busy),
        .op_valid(op_valid), .op_code(op_code), .op_ring(op_ring),
        .op_ack(op_ack), .addr_valid(addr_valid), .addr(addr),
        .sh_we(sh_we), .sh_waddr(sh_waddr), .sh_wdata(sh_wdata),
        .sh_raddr(sh_raddr), .sh_rdata(sh_rdata), .msg_room(msg_room)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int epp_of(input int r);
        return (r == 0) ? 4 : (r == 1) ? 8 : 2;
    endfunction

    function automatic int dsz_of(input int r);
        return (r == 0) ? 128 : (r == 1) ? 32 : 64;
    endfunction

    function automatic logic [31:0] exp_of(input int size);
        logic [31:0] e;
        e = 1;
        while (((size - 1) >> e) != 0) e++;
        return e;
    endfunction

    function automatic logic [AW-1:0] model_addr(input int r);
        logic [31:0] idx;
        int pg;
        logic [AW-1:0] b;
        idx = mptr[r] & mmask[r];
        pg = int'(idx / epp_of(r));
        b = (pg < MP) ? mbase[r][pg] : '0;
        return b + AW'((idx % epp_of(r)) * dsz_of(r));
    endfunction

    function automatic logic model_room();
        return (msh[2][0] - msh[2][1]) < (mmask[2] + 32'd1);
    endfunction

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        sh_raddr = a;
        #1;
        d = sh_rdata;
    endtask

    task automatic setup(input int r, input int n);
        logic [31:0] v;
        @(negedge clk);
        cfg_start = 1'b1; cfg_ring = 2'(r); cfg_npages = CW'(n);
        @(negedge clk);
        cfg_start = 1'b0;
        chk("R1 busy after start", 64'(cfg_busy), 64'd1);
        for (int p = 0; p < n; p++) begin
            cfg_ppn_valid = 1'b1;
            cfg_ppn = PW'(32'h100 + r * 16 + p);
            mbase[r][p] = AW'(32'h100 + r * 16 + p) << PS;
            @(negedge clk);
        end
        cfg_ppn_valid = 1'b0;
        chk("R1 busy in commit", 64'(cfg_busy), 64'd1);
        @(negedge clk);
        chk("R1 idle after commit", 64'(cfg_busy), 64'd0);
        mmask[r] = (32'd1 << exp_of(n * epp_of(r))) - 32'd1;
        mptr[r] = 0;
        msh[r][0] = 0; msh[r][1] = 0; msh[r][2] = exp_of(n * epp_of(r));
        rd(4'(r * 4 + 2), v);
        chk("R2 exponent word", 64'(v), 64'(msh[r][2]));
        rd(4'(r * 4 + 0), v);
        chk("R3 producer cleared", 64'(v), 64'd0);
        rd(4'(r * 4 + 1), v);
        chk("R3 consumer cleared", 64'(v), 64'd0);
    endtask

    task automatic hwrite(input int r, input int f, input logic [31:0] d);
        @(negedge clk);
        sh_we = 1'b1; sh_waddr = 4'(r * 4 + f); sh_wdata = d;
        @(negedge clk);
        sh_we = 1'b0;
        if (r < 3 && f < 3) msh[r][f] = d;
    endtask

    task automatic do_op(input int code, input int r, input string req);
        logic e_ack, e_val;
        logic [AW-1:0] e_addr;
        logic [31:0] v;
        e_ack = (r < 3) && (code < 3);
        e_val = 1'b0;
        e_addr = '0;
        if (e_ack && code == 0) begin
            if (r != 0 || msh[0][0] != mptr[0]) begin
                e_val = 1'b1;
                e_addr = model_addr(r);
            end
        end
        @(negedge clk);
        op_valid = 1'b1; op_code = 2'(code); op_ring = 2'(r);
        @(negedge clk);
        op_valid = 1'b0;
        chk({req, " ack"}, 64'(op_ack), 64'(e_ack));
        chk({req, " valid"}, 64'(addr_valid), 64'(e_val));
        chk({req, " addr"}, 64'(addr), 64'(e_addr));
        if (e_ack) begin
            if (code == 0 && e_val) mptr[r] = mptr[r] + 1;
            if (code == 1) begin
                if (r == 0) msh[0][1] = mptr[0];
                else msh[r][0] = mptr[r];
                rd(4'(r * 4 + ((r == 0) ? 1 : 0)), v);
                chk("R8 flushed word", 64'(v), 64'(mptr[r]));
            end
            if (code == 2) begin
                for (int k = 0; k < 3; k++) begin
                    mptr[k] = 0; mmask[k] = 0;
                    for (int p = 0; p < MP; p++) mbase[k][p] = '0;
                end
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        for (int k = 0; k < 3; k++) begin
            mptr[k] = 0; mmask[k] = 0;
            for (int f = 0; f < 3; f++) msh[k][f] = 0;
            for (int p = 0; p < MP; p++) mbase[k][p] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk("R1 reset busy", 64'(cfg_busy), 64'd0);
        chk("R10 reset ack", 64'(op_ack), 64'd0);
        chk("R10 reset valid", 64'(addr_valid), 64'd0);
        chk("R7 reset room", 64'(msg_room), 64'd1);
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), v);
            chk("R11 reset word", 64'(v), 64'd0);
        end

        // R11: unused address ignores write
        hwrite(0, 3, 32'h55);
        rd(4'd3, v);
        chk("R11 hole write ignored", 64'(v), 64'd0);

        // R3: stale shared indices are cleared by setup
        hwrite(0, 0, 32'd5);
        hwrite(0, 1, 32'd6);
        setup(0, 2);
        setup(1, 3);
        setup(2, 1);

        // R1: invalid starts ignored
        @(negedge clk);
        cfg_start = 1'b1; cfg_ring = 2'd1; cfg_npages = '0;
        @(negedge clk);
        cfg_start = 1'b0;
        chk("R1 zero page count ignored", 64'(cfg_busy), 64'd0);
        @(negedge clk);
        cfg_start = 1'b1; cfg_ring = 2'd3; cfg_npages = CW'(1);
        @(negedge clk);
        cfg_start = 1'b0;
        chk("R1 ring 3 ignored", 64'(cfg_busy), 64'd0);

        // vector table: R4 R5 R7 R8
        for (int i = 0; i < NV; i++) begin
            int kind, r;
            kind = int'(VEC[i][11:10]);
            r = int'(VEC[i][9:8]);
            case (kind)
                0: do_op(0, r, "R4/R5 pop");
                1: do_op(1, r, "R8 flush");
                2: hwrite(r, 0, 32'(VEC[i][7:0]));
                default: hwrite(r, 1, 32'(VEC[i][7:0]));
            endcase
            #1;
            chk("R7 message room", 64'(msg_room), 64'(model_room()));
        end

        // R10: invalid codes and rings ignored
        do_op(3, 1, "R10 code 3");
        do_op(0, 3, "R10 ring 3");

        // R10: op in same cycle as an accepted setup is ignored; op during load ignored
        @(negedge clk);
        cfg_start = 1'b1; cfg_ring = 2'd0; cfg_npages = CW'(3);
        op_valid = 1'b1; op_code = 2'd0; op_ring = 2'd1;
        @(negedge clk);
        cfg_start = 1'b0;
        chk("R10 op with setup not acked", 64'(op_ack), 64'd0);
        @(negedge clk);
        chk("R10 op during load not acked", 64'(op_ack), 64'd0);
        op_valid = 1'b0;
        for (int p = 0; p < 3; p++) begin
            cfg_ppn_valid = 1'b1;
            cfg_ppn = PW'(32'h200 + p);
            mbase[0][p] = AW'(32'h200 + p) << PS;
            @(negedge clk);
        end
        cfg_ppn_valid = 1'b0;
        @(negedge clk);
        mptr[0] = 0; msh[0][0] = 0; msh[0][1] = 0; msh[0][2] = exp_of(12);
        mmask[0] = (32'd1 << exp_of(12)) - 32'd1;
        rd(4'd2, v);
        chk("R2 exponent for 12 entries", 64'(v), 64'd4);
        do_op(0, 1, "R10 cmp pointer untouched by ignored op");

        // R6: completion ring wraps without failing
        for (int k = 0; k < 40; k++) do_op(0, 1, "R6 cmp wrap pop");

        // R11: block flush wins over host write to the same word
        @(negedge clk);
        op_valid = 1'b1; op_code = 2'd1; op_ring = 2'd1;
        sh_we = 1'b1; sh_waddr = 4'd4; sh_wdata = 32'hABCD;
        @(negedge clk);
        op_valid = 1'b0; sh_we = 1'b0;
        msh[1][0] = mptr[1];
        rd(4'd4, v);
        chk("R11 internal write wins", 64'(v), 64'(mptr[1]));

        // R9: cleanup
        do_op(2, 0, "R9 cleanup");
        rd(4'd2, v);
        chk("R9 shared exponent kept", 64'(v), 64'd4);
        do_op(0, 1, "R9 cmp pop after cleanup");
        hwrite(0, 0, 32'd7);
        do_op(0, 0, "R9 req pop after cleanup");
        #1;
        chk("R9 room with zero mask", 64'(msg_room), 64'(model_room()));

        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule